// File: doc/BRIEF.md
# Receive Early-Event Interrupt Generator

This block sits beside a receive byte stream and tells the host, before a frame has finished arriving, that the frame has begun and is worth looking at. It counts the bytes of each frame from its first byte. When the six address bytes have arrived, it takes a pass or fail verdict from an external address filter. A frame that fails is marked for discard and produces no events. A frame that passes raises an address event. If the frame grows to 128 bytes, a second event replaces the first.

Both events sit in a 16-bit event word that the host reads. A read strobe clears the word. Each event drives a level-sensitive interrupt only when the matching bit of a 16-bit configuration word is set. The address matching, acceptance filtering, buffering and DMA are handled by other blocks.

Top module: `rxe_early_evt`

## Requirements
- R1: Byte positions count from 1. The byte presented with `rx_vld` and `rx_sof` both high is byte 1. Every `rx_sof` byte restarts the count, even in the middle of a frame. Valid bytes that arrive outside a frame (after `rx_eof` and before the next `rx_sof`) are ignored.
- R2: If `da_pass` is low on byte 6, `discard` goes high on the next clock edge and stays high until the next `rx_sof` byte. A frame marked this way raises neither event.
- R3: If `da_pass` is high on byte 6 and the frame is not discarded, bit 15 of `evt_word` (the address event) is set at the next clock edge.
- R4: The first time byte 128 of a frame that is not discarded is taken, bit 11 of `evt_word` (the 128-byte event) is set at the next clock edge.
- R5: On the edge where bit 11 is set, bit 15 is cleared.
- R6: A cycle with `host_rd` high clears both event bits at the next edge.
- R7: If an event is set in the same cycle as a host read, the set wins and the bit ends up set.
- R8: `irq` is the combinational OR of `evt_word & cfg_word`. Bit 15 of `cfg_word` enables the address event and bit 11 enables the 128-byte event. `irq` is low whenever no enabled event is set.
- R9: A frame that ends before byte 128 never sets bit 11. A frame that ends before byte 6 sets neither bit and is never discarded.
- R10: Every bit of `evt_word` other than 15 and 11 is always zero. After reset `evt_word` is zero and `discard` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_eof | input | 1 | The present byte is the last byte of a frame |
| da_pass | input | 1 | Address filter verdict, sampled on byte 6 |
| host_rd | input | 1 | Host read of the event word; clears the events |
| cfg_word | input | 16 | Interrupt enables (bit 15 address, bit 11 128-byte) |
| evt_word | output | 16 | Event word (bit 15 address, bit 11 128-byte) |
| irq | output | 1 | Level interrupt |
| discard | output | 1 | The current frame failed the address filter |

## Verification
A byte counter that is off by one moves the event edge by a cycle. The bench samples one cycle after byte 6 and one cycle after byte 128, so a shifted edge shows up at once. A counter that does not restart on `rx_sof`, or that keeps counting outside a frame, raises the 128-byte event on a frame that is too short; the bench catches this at the end of that frame. A discard flag that is lost or stuck shows up as a wrong event bit or a wrong `discard` level at the end of the next frame. Wrong set-or-clear priority shows up on the edge that follows a read which coincides with a set.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
    // Event word layout (decoded by the host)
    localparam int EVT_W     = 16;
    localparam int ADDR_BIT  = 15;
    localparam int EARLY_BIT = 11;

    localparam logic [EVT_W-1:0] EVT_MASK =
        (EVT_W'(1) << ADDR_BIT) | (EVT_W'(1) << EARLY_BIT);

    typedef struct packed {
        logic addr;
        logic early;
    } evt_st_t;
endpackage

// File: rtl/rxe_byte_track.sv
module rxe_byte_track #(
    parameter int ADDR_BYTES  = 6,
    parameter int EARLY_BYTES = 128,
    localparam int CNT_W      = $clog2(EARLY_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_vld,
    input  logic rx_sof,
    input  logic rx_eof,
    input  logic da_pass,
    output logic hit_addr,
    output logic hit_early,
    output logic discard
);
    localparam logic [CNT_W-1:0] ADDR_C  = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] EARLY_C = CNT_W'(EARLY_BYTES);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic             discard;
        logic [CNT_W-1:0] cnt;
    } trk_st_t;

    trk_st_t st_d, st_q;

    logic             start;
    logic             in_frame;
    logic [CNT_W-1:0] pos;
    logic             disc_now;
    logic             addr_byte;
    logic             addr_fail;
    logic             fresh_early;

    always_comb begin
        start       = rx_vld && rx_sof;
        in_frame    = rx_vld && (rx_sof || st_q.active);
        pos         = start ? ONE_C
                    : ((st_q.cnt == EARLY_C) ? EARLY_C : st_q.cnt + ONE_C);
        disc_now    = start ? 1'b0 : st_q.discard;
        addr_byte   = in_frame && (pos == ADDR_C);
        addr_fail   = addr_byte && !da_pass;
        fresh_early = start || (st_q.cnt != EARLY_C);

        hit_addr  = addr_byte && da_pass && !disc_now;
        hit_early = in_frame && (pos == EARLY_C) && fresh_early
                    && !disc_now && !addr_fail;

        st_d = st_q;
        if (in_frame) begin
            st_d.active  = !rx_eof;
            st_d.cnt     = pos;
            st_d.discard = disc_now || addr_fail;
        end
        discard = st_q.discard;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= EARLY_C) else $error("count above limit"); // R1
    AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.discard && !start) |-> (!hit_addr && !hit_early))
        else $error("event from discarded frame"); // R2
    AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start) |=> $stable(st_q.cnt))
        else $error("count moved outside frame"); // R1
endmodule

// File: rtl/rxe_event_reg.sv
module rxe_event_reg
    import rxe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_addr,
    input  logic             hit_early,
    input  logic             host_rd,
    output logic [EVT_W-1:0] evt_word
);
    evt_st_t ev_d, ev_q;

    always_comb begin
        ev_d = ev_q;
        if (host_rd) begin
            ev_d.addr  = 1'b0;
            ev_d.early = 1'b0;
        end
        if (hit_addr) begin
            ev_d.addr = 1'b1;
        end
        if (hit_early) begin
            ev_d.early = 1'b1;
            ev_d.addr  = 1'b0;
        end

        evt_word            = '0;
        evt_word[ADDR_BIT]  = ev_q.addr;
        evt_word[EARLY_BIT] = ev_q.early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_early |=> ev_q.early) else $error("early set lost"); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !hit_addr && !hit_early) |=> (!ev_q.addr && !ev_q.early))
        else $error("read did not clear"); // R6
    AST_EARLY_DROPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_q.early) |-> !ev_q.addr) else $error("address kept"); // R5
endmodule

// File: rtl/rxe_irq_gate.sv
module rxe_irq_gate
    import rxe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_word,
    input  logic [EVT_W-1:0] cfg_word,
    output logic             irq
);
    logic [EVT_W-1:0] live;

    for (genvar g = 0; g < EVT_W; g++) begin : g_gate
        assign live[g] = evt_word[g] & cfg_word[g];
    end

    assign irq = |live;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word == '0) |-> !irq) else $error("irq with no event"); // R8
endmodule

// File: rtl/rxe_early_evt.sv
module rxe_early_evt
    import rxe_pkg::*;
#(
    parameter int ADDR_BYTES  = 6,
    parameter int EARLY_BYTES = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_vld,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             da_pass,
    input  logic             host_rd,
    input  logic [EVT_W-1:0] cfg_word,
    output logic [EVT_W-1:0] evt_word,
    output logic             irq,
    output logic             discard
);
    logic hit_addr;
    logic hit_early;

    rxe_byte_track #(
        .ADDR_BYTES (ADDR_BYTES),
        .EARLY_BYTES(EARLY_BYTES)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_vld   (rx_vld),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .da_pass  (da_pass),
        .hit_addr (hit_addr),
        .hit_early(hit_early),
        .discard  (discard)
    );

    rxe_event_reg u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_addr (hit_addr),
        .hit_early(hit_early),
        .host_rd  (host_rd),
        .evt_word (evt_word)
    );

    rxe_irq_gate u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_word(evt_word),
        .cfg_word(cfg_word),
        .irq     (irq)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_word & ~EVT_MASK) == '0) else $error("reserved bit set"); // R10
    AST_FAIL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(discard) |-> !hit_addr) else $error("address event on fail"); // R2
endmodule

// File: tb/test_rxe_early_evt.sv
module test_rxe_early_evt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic        da_pass = 1'b1, host_rd = 1'b0;
    logic [15:0] cfg_word = 16'h0000;
    logic [15:0] evt_word;
    logic        irq, discard;

    int chk_cnt = 0;
    int fail_cnt = 0;

    always #10 clk = ~clk; // 50 MHz

    rxe_early_evt i_rxe_early_evt (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .da_pass(da_pass), .host_rd(host_rd),
        .cfg_word(cfg_word), .evt_word(evt_word), .irq(irq),
        .discard(discard)
    );

    typedef struct packed {
        logic [15:0] len;
        logic        pass;
        logic [15:0] cfg;
        logic [15:0] evt;
        logic        irq;
        logic        disc;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd10,  1'b1, 16'h8000, 16'h8000, 1'b1, 1'b0},
        '{16'd10,  1'b0, 16'h8800, 16'h0000, 1'b0, 1'b1},
        '{16'd200, 1'b1, 16'h0800, 16'h0800, 1'b1, 1'b0},
        '{16'd200, 1'b1, 16'h8000, 16'h0800, 1'b0, 1'b0},
        '{16'd127, 1'b1, 16'h8800, 16'h8000, 1'b1, 1'b0},
        '{16'd128, 1'b1, 16'h0000, 16'h0800, 1'b0, 1'b0},
        '{16'd5,   1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        '{16'd6,   1'b1, 16'h7FFF, 16'h8000, 1'b0, 1'b0},
        '{16'd300, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive, take the edge, release at negedge; outputs then settled.
    task automatic cyc(input logic v, input logic s, input logic e,
                       input logic r);
        rx_vld = v; rx_sof = s; rx_eof = e; host_rd = r;
        @(posedge clk);
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; host_rd = 1'b0;
    endtask

    task automatic bytes(input int from, input int to, input int last);
        for (int i = from; i <= to; i++) cyc(1'b1, i == 1, i == last, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fail_cnt++;
        $display("FAIL watchdog R1: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 chk_cnt, fail_cnt);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R10 reset evt", evt_word, 16'h0000);
        check("R10 reset discard", {15'd0, discard}, 16'd0);
        check("R8 reset irq", {15'd0, irq}, 16'd0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: clear, send one frame, compare outputs at its end.
        for (int k = 0; k < NV; k++) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b1);
            cfg_word = VECS[k].cfg;
            da_pass  = VECS[k].pass;
            bytes(1, int'(VECS[k].len), int'(VECS[k].len));
            check($sformatf("R3/R4/R9 vec%0d evt", k), evt_word, VECS[k].evt);
            check($sformatf("R8 vec%0d irq", k), {15'd0, irq},
                  {15'd0, VECS[k].irq});
            check($sformatf("R2 vec%0d discard", k), {15'd0, discard},
                  {15'd0, VECS[k].disc});
        end

        // Exact edges of both events.
        da_pass = 1'b1; cfg_word = 16'h8800;
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        bytes(1, 5, 500);
        check("R3 before byte 6", evt_word, 16'h0000);
        bytes(6, 6, 500);
        check("R3 after byte 6", evt_word, 16'h8000);
        bytes(7, 127, 500);
        check("R4 before byte 128", evt_word, 16'h8000);
        bytes(128, 128, 500);
        check("R5 byte 128 swaps events", evt_word, 16'h0800);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        check("R6 read clears", evt_word, 16'h0000);
        check("R8 irq drops", {15'd0, irq}, 16'd0);
        bytes(129, 200, 200);
        check("R4 no second 128 event", evt_word, 16'h0000);

        // Read coinciding with a set.
        bytes(1, 5, 300);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        check("R7 read with address set", evt_word, 16'h8000);
        bytes(7, 127, 300);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        check("R7 read with 128 set", evt_word, 16'h0800);
        bytes(129, 300, 300);

        // Idle bytes ignored; mid-frame restart.
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 200; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R1 bytes outside frame ignored", evt_word, 16'h0000);
        bytes(1, 100, 1000);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        bytes(1, 30, 1000);
        check("R1 restart on sof", evt_word, 16'h8000);
        bytes(31, 128, 128);
        check("R1 counted from restart", evt_word, 16'h0800);

        // Discard persists to next sof, then clears.
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        da_pass = 1'b0;
        bytes(1, 20, 20);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        check("R2 discard held", {15'd0, discard}, 16'd1);
        da_pass = 1'b1;
        bytes(1, 1, 3);
        check("R2 discard cleared by sof", {15'd0, discard}, 16'd0);
        bytes(2, 3, 3);
        check("R9 short frame no event", evt_word, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 chk_cnt, fail_cnt);
        $finish;
    end
endmodule